// File: doc/BRIEF.md
# Staggered Output Driver Inhibit Sequencer

During manufacturing test, a chip with many three-state output pads should not let those pads switch while test clocks fire. It should also not let all of them turn back on in the same instant. This block takes the test-mode flag, the scan-enable level, a test-clock pulse indication and a mask of the pins that carry scan-out data. From these it produces one inhibit line per driver group and a final output-enable per pin.

Any test-clock pulse, whether shift or capture, forces every group into high impedance in the same cycle the pulse is seen. While scan-enable is high, only the masked scan-out pins are allowed to drive. Once the request goes away, the groups are released one after another, lowest index first. The gap between releases comes from a run-time gap input. A new request arriving mid-release re-inhibits everything at once, and the release sequence later restarts from group 0.

Outside test mode the block is transparent: every pin follows its functional enable. Pins are split into groups of equal size, so the pin count must be a multiple of the group count. The reset input is asynchronous and active low. Its deassertion is expected to be already synchronous to `clk`.

Top module: `odi_stagger_seq`

## Requirements
- R1: With test mode high and a test-clock pulse indicated, all group inhibit bits are 1 in that same cycle, and with scan enable low every pin enable is 0 in that cycle.
- R2: With test mode and scan enable high, the pin enable vector equals the scan-out mask exactly: a masked pin is driven (1), every other pin is disabled (0), and all group inhibit bits are 1.
- R3: Pin p belongs to group p / (NUM_PINS/NUM_GROUPS). Outside the shift exemption, pin p is enabled exactly when its functional enable is 1 and its group's inhibit bit is 0.
- R4: Groups are released in ascending index order, with at most one group changing from inhibited to released per cycle.
- R5: Let the first cycle with the request low be index 0 and let the gap input be G. Then inhibit bit k is 0 from index (k+1)*(G+1) onward, and 1 before that.
- R6: A request arriving partway through a release sets all group inhibit bits to 1 in that cycle. After it ends, the timing of R5 applies again from index 0, starting with group 0.
- R7: With test mode low, every group inhibit bit is 0 and the pin enables equal the functional enables. Sequencer state is cleared, so on re-entering test mode all groups stay released until a request arrives.
- R8: Reset sets all groups inhibited with the sequence armed. With test mode high and no request, the groups are released per R5, where index 0 is the first cycle after reset deassertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Manufacturing test mode active |
| scan_en_i | input | 1 | Scan shift enable level |
| tclk_pulse_i | input | 1 | A test clock pulse (shift or capture) occurs this cycle |
| scan_out_mask_i | input | NUM_PINS | 1 marks a pin currently carrying scan-out data |
| func_oe_i | input | NUM_PINS | Functional output enables |
| stagger_gap_i | input | GAP_W | Extra cycles between successive group releases |
| grp_inhibit_o | output | NUM_GROUPS | 1 forces the group's drivers to high impedance |
| pin_oe_o | output | NUM_PINS | Final per-pin output enable |

## Verification
The assertions take for granted that the gap input does not change while a release is in progress. Otherwise the counter could run past the new value and break the release spacing. They also take for granted that all inputs are stable around the clock edge. The stimulus changes the gap only while the sequencer is idle or while a request is holding every group. It drives every input just after a rising edge. Stimulus covers every scan-out mask value and every functional enable value, and sweeps the gap from 0 to 5. Releases are interrupted mid-sequence and test mode is dropped mid-sequence.

// File: rtl/odi_pkg.sv
`timescale 1ns/1ps
package odi_pkg;

  typedef enum logic {
    SEQ_IDLE    = 1'b0,
    SEQ_STAGGER = 1'b1
  } seq_state_e;

endpackage

// File: rtl/odi_req_decode.sv
`timescale 1ns/1ps
module odi_req_decode (
  input  logic test_mode_i,
  input  logic scan_en_i,
  input  logic tclk_pulse_i,
  output logic hold_req_o,
  output logic shift_exempt_o
);

  // Any test clock, or a shift window, holds every driver off.
  assign hold_req_o     = test_mode_i & (scan_en_i | tclk_pulse_i);
  // Scan-out pins are allowed to drive only while shifting.
  assign shift_exempt_o = test_mode_i & scan_en_i;

endmodule

// File: rtl/odi_release_seq.sv
`timescale 1ns/1ps
module odi_release_seq
  import odi_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GAP_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode_i,
  input  logic                  hold_req_i,
  input  logic [GAP_W-1:0]      gap_i,
  output logic [NUM_GROUPS-1:0] inh_state_o
);

  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_GROUPS - 1);

  seq_state_e            st_q,  st_d;
  logic [NUM_GROUPS-1:0] inh_q, inh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [GAP_W-1:0]      cnt_q, cnt_d;
  logic                  seq_en;

  // Registers change only when something is pending or being cleared.
  always_comb begin
    if (!test_mode_i) begin
      seq_en = (st_q != SEQ_IDLE) | (|inh_q);
    end else begin
      seq_en = hold_req_i | (st_q == SEQ_STAGGER);
    end
  end

  always_comb begin
    st_d  = st_q;
    inh_d = inh_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (!test_mode_i) begin
      st_d  = SEQ_IDLE;
      inh_d = '0;
      idx_d = '0;
      cnt_d = '0;
    end else if (hold_req_i) begin
      // Re-arm from group 0 on every request.
      st_d  = SEQ_STAGGER;
      inh_d = '1;
      idx_d = '0;
      cnt_d = '0;
    end else if (st_q == SEQ_STAGGER) begin
      if (cnt_q == gap_i) begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (idx_q == IDX_W'(g)) begin
            inh_d[g] = 1'b0;
          end
        end
        cnt_d = '0;
        if (idx_q == LAST_IDX) begin
          st_d  = SEQ_IDLE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_STAGGER;
      inh_q <= '1;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      inh_q <= inh_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign inh_state_o = inh_q;

endmodule

// File: rtl/odi_pin_gate.sv
`timescale 1ns/1ps
module odi_pin_gate #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS-1:0] grp_inhibit_i,
  input  logic                  shift_exempt_i,
  input  logic [NUM_PINS-1:0]   scan_out_mask_i,
  input  logic [NUM_PINS-1:0]   func_oe_i,
  output logic [NUM_PINS-1:0]   pin_oe_o
);

  localparam int PINS_PER_GRP = NUM_PINS / NUM_GROUPS;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int GIDX = p / PINS_PER_GRP;
    assign pin_oe_o[p] = (shift_exempt_i & scan_out_mask_i[p])
                       | (func_oe_i[p] & ~grp_inhibit_i[GIDX]);
  end

endmodule

// File: rtl/odi_stagger_seq.sv
`timescale 1ns/1ps
module odi_stagger_seq #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_GROUPS = 4,
  parameter int GAP_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode_i,
  input  logic                  scan_en_i,
  input  logic                  tclk_pulse_i,
  input  logic [NUM_PINS-1:0]   scan_out_mask_i,
  input  logic [NUM_PINS-1:0]   func_oe_i,
  input  logic [GAP_W-1:0]      stagger_gap_i,
  output logic [NUM_GROUPS-1:0] grp_inhibit_o,
  output logic [NUM_PINS-1:0]   pin_oe_o
);

  logic                  hold_req;
  logic                  shift_exempt;
  logic [NUM_GROUPS-1:0] inh_state;

  odi_req_decode u_req (
    .test_mode_i    (test_mode_i),
    .scan_en_i      (scan_en_i),
    .tclk_pulse_i   (tclk_pulse_i),
    .hold_req_o     (hold_req),
    .shift_exempt_o (shift_exempt)
  );

  odi_release_seq #(
    .NUM_GROUPS (NUM_GROUPS),
    .GAP_W      (GAP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode_i (test_mode_i),
    .hold_req_i  (hold_req),
    .gap_i       (stagger_gap_i),
    .inh_state_o (inh_state)
  );

  // Assertion is immediate on request; release comes from the sequencer.
  assign grp_inhibit_o = {NUM_GROUPS{test_mode_i}}
                       & (inh_state | {NUM_GROUPS{hold_req}});

  odi_pin_gate #(
    .NUM_PINS   (NUM_PINS),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_gate (
    .grp_inhibit_i   (grp_inhibit_o),
    .shift_exempt_i  (shift_exempt),
    .scan_out_mask_i (scan_out_mask_i),
    .func_oe_i       (func_oe_i),
    .pin_oe_o        (pin_oe_o)
  );

endmodule

// File: rtl/odi_stagger_seq_chk.sv
`timescale 1ns/1ps
module odi_stagger_seq_chk #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  test_mode_i,
  input logic                  scan_en_i,
  input logic                  tclk_pulse_i,
  input logic [NUM_PINS-1:0]   scan_out_mask_i,
  input logic [NUM_PINS-1:0]   func_oe_i,
  input logic [NUM_GROUPS-1:0] grp_inhibit_o,
  input logic [NUM_PINS-1:0]   pin_oe_o
);

  AST_PULSE_ALL_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && tclk_pulse_i) |-> (&grp_inhibit_o)); // R1

  AST_PULSE_PINS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && tclk_pulse_i && !scan_en_i) |-> (pin_oe_o == '0)); // R1

  AST_SHIFT_MASK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && scan_en_i) |-> (pin_oe_o == scan_out_mask_i)); // R2

  AST_ONE_RELEASE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && $past(test_mode_i))
      |-> ($countones($past(grp_inhibit_o) & ~grp_inhibit_o) <= 1)); // R4

  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_order
    AST_ASCENDING_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode_i && $past(test_mode_i) && $fell(grp_inhibit_o[g]))
        |-> ($past(grp_inhibit_o[g-1]) == 1'b0)); // R4
  end

  AST_HOLD_AFTER_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && $past(test_mode_i && (scan_en_i || tclk_pulse_i)))
      |-> (&grp_inhibit_o)); // R6

  AST_MODE_OFF_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode_i) |-> ((grp_inhibit_o == '0) && (pin_oe_o == func_oe_i))); // R7

endmodule

bind odi_stagger_seq odi_stagger_seq_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_GROUPS (NUM_GROUPS)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .test_mode_i     (test_mode_i),
  .scan_en_i       (scan_en_i),
  .tclk_pulse_i    (tclk_pulse_i),
  .scan_out_mask_i (scan_out_mask_i),
  .func_oe_i       (func_oe_i),
  .grp_inhibit_o   (grp_inhibit_o),
  .pin_oe_o        (pin_oe_o)
);

// File: tb/odi_stagger_seq_tb_top.sv
`timescale 1ns/1ps
module odi_stagger_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int NG  = 4;
  localparam int GW  = 4;
  localparam int PPG = NP / NG;

  logic          clk;
  logic          rst_n;
  logic          tm;
  logic          se;
  logic          tclk;
  logic [NP-1:0] mask;
  logic [NP-1:0] func;
  logic [GW-1:0] gap;
  logic [NG-1:0] grp;
  logic [NP-1:0] pins;

  int n_chk;
  int n_bad;

  odi_stagger_seq #(.NUM_PINS(NP), .NUM_GROUPS(NG), .GAP_W(GW)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .test_mode_i     (tm),
    .scan_en_i       (se),
    .tclk_pulse_i    (tclk),
    .scan_out_mask_i (mask),
    .func_oe_i       (func),
    .stagger_gap_i   (gap),
    .grp_inhibit_o   (grp),
    .pin_oe_o        (pins)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NG-1:0] exp_grp(input int idx, input int g);
    logic [NG-1:0] r;
    for (int k = 0; k < NG; k++) r[k] = (idx < (k + 1) * (g + 1));
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_pins(input logic m, input logic s,
      input logic [NP-1:0] mk, input logic [NP-1:0] f, input logic [NG-1:0] gi);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      if (m && s && mk[p]) r[p] = 1'b1;
      else if (m)          r[p] = f[p] & ~gi[p / PPG];
      else                 r[p] = f[p];
    end
    return r;
  endfunction

  // Checks release indices from..upto; the caller is at the start of index 'from'.
  task automatic run_release(input string tag, input int from, input int upto);
    for (int i = from; i <= upto; i++) begin
      func = NP'(8'h5A ^ (i * 37));
      #1;
      chk({tag, " grp"}, 32'(grp), 32'(exp_grp(i, int'(gap))));
      chk({"R3 pins/", tag}, 32'(pins), 32'(exp_pins(1'b1, 1'b0, mask, func, exp_grp(i, int'(gap)))));
      nxt();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    tm = 1'b1; se = 1'b0; tclk = 1'b0;
    mask = '0; func = '1; gap = GW'(1);
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state.
    chk("R8 reset grp", 32'(grp), 32'hF);
    chk("R8 reset pins", 32'(pins), 32'h0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run_release("R8", 0, 4 * 2 + 2);

    // R7: transparent outside test mode, whatever the other inputs do.
    tm = 1'b0;
    for (int v = 0; v < 256; v++) begin
      func = NP'(v);
      se = v[0];
      tclk = v[1];
      mask = NP'(v * 7);
      #1;
      chk("R7 grp", 32'(grp), 32'h0);
      chk("R7 pins", 32'(pins), 32'(func));
      nxt();
    end
    se = 1'b0; tclk = 1'b0; mask = '0;

    // R1/R4/R5/R3: pulse then release across gap values.
    tm = 1'b1;
    for (int g = 0; g <= 5; g++) begin
      gap = GW'(g);
      tclk = 1'b1;
      func = '1;
      #1;
      chk("R1 grp", 32'(grp), 32'hF);
      chk("R1 pins", 32'(pins), 32'h0);
      nxt();
      tclk = 1'b0;
      run_release("R5", 0, 4 * (g + 1) + 1);
    end

    // R7: drop test mode mid-release, re-enter: nothing inhibited until a request.
    gap = GW'(3);
    tclk = 1'b1;
    nxt();
    tclk = 1'b0;
    repeat (5) nxt();
    tm = 1'b0;
    nxt();
    tm = 1'b1;
    func = 8'hC3;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R7 re-enter grp", 32'(grp), 32'h0);
      chk("R7 re-enter pins", 32'(pins), 32'hC3);
      nxt();
    end

    // R2: shift window, sweep every mask.
    se = 1'b1;
    for (int v = 0; v < 256; v++) begin
      mask = NP'(v);
      func = NP'(~v);
      tclk = v[0];
      #1;
      chk("R2 pins", 32'(pins), 32'(mask));
      chk("R2 grp", 32'(grp), 32'hF);
      nxt();
    end
    se = 1'b0; tclk = 1'b0;
    gap = GW'(0);
    run_release("R2 exit", 0, 5);
    mask = '0;

    // R6: interrupt a release after two groups are out.
    gap = GW'(2);
    tclk = 1'b1;
    nxt();
    tclk = 1'b0;
    run_release("R6", 0, 6);
    tclk = 1'b1;
    func = '1;
    #1;
    chk("R6 re-inhibit grp", 32'(grp), 32'hF);
    chk("R6 re-inhibit pins", 32'(pins), 32'h0);
    nxt();
    tclk = 1'b0;
    run_release("R6 restart", 0, 13);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule